// File: doc/BRIEF.md
# Destination-Keyed Predicate Map

This block holds a small configuration table that ties destination registers to predicate registers. An instruction does not name its predicate. Instead, decode asks this block whether the destination register of an integer or floating-point operation is predicated. If it is, the block returns the integer register whose bits act as a per-element mask.

Software writes one of sixteen table slots at a time through a plain write port. On every write the block rebuilds an internal reverse map, with an enable flag and a predicate index for each of the 32 integer registers and each of the 32 floating-point registers. The rebuild happens in the same clock edge that stores the slot, so a query costs only one array index.

Queries travel on a valid/ready stream. A query is accepted when `lk_valid` and `lk_ready` are both high, and its answer appears on the response stream in the next cycle. The block accepts a new query only while the response slot is empty or that slot is being drained in the same cycle. While `rs_valid` is high and `rs_ready` is low, the response holds steady and new queries wait.

Top module: `dest_pred_map`

## Requirements
- R1: A table write with `cfg_wr_en` high stores `cfg_wr_data` in slot `cfg_wr_addr` (0 to 15). The word has these fields: bits [4:0] are the target register index, bit 5 is the file type (0 integer, 1 floating point), bit 6 is the enable, and bits [11:7] are the predicate register index.
- R2: For a slot with its enable set, a query of that target register in that slot's file returns `rs_pred_en` = 1 and `rs_pred_reg` equal to the slot's predicate index.
- R3: A slot with its enable clear has no effect on any query result.
- R4: The query input `lk_is_fp` picks the floating-point map when it is 1 and the integer map when it is 0. A slot marks a register only in the file its type bit names.
- R5: When several enabled slots name the same target in the same file, the slot with the highest index supplies the predicate index.
- R6: A query accepted in the cycle after a write sees the new table. A query accepted in the same cycle as a write sees the table as it was before that write. Overwriting a slot removes its old mapping.
- R7: After reset, every slot is clear and every query returns `rs_pred_en` = 0.
- R8: A query is accepted when `lk_valid` && `lk_ready`. `lk_ready` is high exactly when no response is pending or `rs_ready` is high. An accepted query produces `rs_valid` = 1 in the next cycle. `rs_valid` drops after a cycle with `rs_ready` high and no new acceptance.
- R9: While `rs_valid` is 1 and `rs_ready` is 0, `rs_valid`, `rs_pred_en` and `rs_pred_reg` stay unchanged.
- R10: When `rs_pred_en` is 0 in a response, `rs_pred_reg` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_wr_addr | input | 4 | Slot to write |
| cfg_wr_data | input | 12 | Slot contents (fields in R1) |
| lk_valid | input | 1 | Query valid |
| lk_ready | output | 1 | Query accepted this cycle when valid |
| lk_is_fp | input | 1 | Query operation type, 1 = floating point |
| lk_dest | input | 5 | Query destination register index |
| rs_valid | output | 1 | Response valid |
| rs_ready | input | 1 | Response consumer ready |
| rs_pred_en | output | 1 | Destination is predicated |
| rs_pred_reg | output | 5 | Integer register holding the mask |

## Verification
The assertions check the stream rules on every cycle: query acceptance against response slot occupancy, one-cycle response latency, stable responses under back-pressure, the zero predicate index on unpredicated answers, and the empty response slot after reset. The mapping contents are checked only by the bench. It sweeps every destination in both files across several table patterns, including disabled slots, duplicate targets, and writes that land in the same cycle as a query, and it compares each answer with a table model.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int REG_IDX_W = 5;
  localparam int N_REGS    = 1 << REG_IDX_W;

  typedef struct packed {
    logic [REG_IDX_W-1:0] pred;
    logic                 en;
    logic                 is_fp;
    logic [REG_IDX_W-1:0] target;
  } map_entry_t;

  localparam int ENTRY_W = $bits(map_entry_t);
endpackage

// File: rtl/dpm_entry_store.sv
module dpm_entry_store
  import dpm_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int ADDR_W   = $clog2(N_ENTRIES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  map_entry_t                   wr_data,
  output map_entry_t [N_ENTRIES-1:0]   tbl_next
);
  map_entry_t [N_ENTRIES-1:0] tbl_q;

  // Next table contents: the reverse map is built from these so it lands in
  // the same edge as the slot update.
  always_comb begin
    tbl_next = tbl_q;
    if (wr_en) tbl_next[wr_addr] = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tbl_q <= '0;
    else        tbl_q <= tbl_next;
  end
endmodule

// File: rtl/dpm_reverse_builder.sv
module dpm_reverse_builder
  import dpm_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  map_entry_t [N_ENTRIES-1:0]           tbl,
  output logic [N_REGS-1:0]                    int_en,
  output logic [N_REGS-1:0]                    fp_en,
  output logic [N_REGS-1:0][REG_IDX_W-1:0]     int_idx,
  output logic [N_REGS-1:0][REG_IDX_W-1:0]     fp_idx
);
  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    logic                 ie, fe;
    logic [REG_IDX_W-1:0] ii, fi;

    // Ascending scan: a later (higher) slot overrides an earlier one.
    always_comb begin
      ie = 1'b0;
      fe = 1'b0;
      ii = '0;
      fi = '0;
      for (int e = 0; e < N_ENTRIES; e++) begin
        if (tbl[e].en && (tbl[e].target == REG_IDX_W'(r))) begin
          if (tbl[e].is_fp) begin
            fe = 1'b1;
            fi = tbl[e].pred;
          end else begin
            ie = 1'b1;
            ii = tbl[e].pred;
          end
        end
      end
    end

    assign int_en[r]  = ie;
    assign fp_en[r]   = fe;
    assign int_idx[r] = ii;
    assign fp_idx[r]  = fi;
  end
endmodule

// File: rtl/dpm_reverse_regs.sv
module dpm_reverse_regs
  import dpm_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_REGS-1:0]                int_en_d,
  input  logic [N_REGS-1:0]                fp_en_d,
  input  logic [N_REGS-1:0][REG_IDX_W-1:0] int_idx_d,
  input  logic [N_REGS-1:0][REG_IDX_W-1:0] fp_idx_d,
  output logic [N_REGS-1:0]                int_en_q,
  output logic [N_REGS-1:0]                fp_en_q,
  output logic [N_REGS-1:0][REG_IDX_W-1:0] int_idx_q,
  output logic [N_REGS-1:0][REG_IDX_W-1:0] fp_idx_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_en_q  <= '0;
      fp_en_q   <= '0;
      int_idx_q <= '0;
      fp_idx_q  <= '0;
    end else begin
      int_en_q  <= int_en_d;
      fp_en_q   <= fp_en_d;
      int_idx_q <= int_idx_d;
      fp_idx_q  <= fp_idx_d;
    end
  end
endmodule

// File: rtl/dpm_lookup_port.sv
module dpm_lookup_port
  import dpm_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_REGS-1:0]                int_en,
  input  logic [N_REGS-1:0]                fp_en,
  input  logic [N_REGS-1:0][REG_IDX_W-1:0] int_idx,
  input  logic [N_REGS-1:0][REG_IDX_W-1:0] fp_idx,
  input  logic                             lk_valid,
  output logic                             lk_ready,
  input  logic                             lk_is_fp,
  input  logic [REG_IDX_W-1:0]             lk_dest,
  output logic                             rs_valid,
  input  logic                             rs_ready,
  output logic                             rs_pred_en,
  output logic [REG_IDX_W-1:0]             rs_pred_reg
);
  logic                 accept;
  logic                 sel_en;
  logic [REG_IDX_W-1:0] sel_idx;

  assign lk_ready = !rs_valid || rs_ready;
  assign accept   = lk_valid && lk_ready;

  always_comb begin
    sel_en  = lk_is_fp ? fp_en[lk_dest] : int_en[lk_dest];
    sel_idx = '0;
    if (sel_en) sel_idx = lk_is_fp ? fp_idx[lk_dest] : int_idx[lk_dest];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid    <= 1'b0;
      rs_pred_en  <= 1'b0;
      rs_pred_reg <= '0;
    end else if (accept) begin
      rs_valid    <= 1'b1;
      rs_pred_en  <= sel_en;
      rs_pred_reg <= sel_idx;
    end else if (rs_ready) begin
      rs_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/dest_pred_map.sv
module dest_pred_map
  import dpm_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int ADDR_W   = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [ADDR_W-1:0]    cfg_wr_addr,
  input  logic [ENTRY_W-1:0]   cfg_wr_data,
  input  logic                 lk_valid,
  output logic                 lk_ready,
  input  logic                 lk_is_fp,
  input  logic [REG_IDX_W-1:0] lk_dest,
  output logic                 rs_valid,
  input  logic                 rs_ready,
  output logic                 rs_pred_en,
  output logic [REG_IDX_W-1:0] rs_pred_reg
);
  map_entry_t [N_ENTRIES-1:0]        tbl_next;
  logic [N_REGS-1:0]                 int_en_d, fp_en_d, int_en_q, fp_en_q;
  logic [N_REGS-1:0][REG_IDX_W-1:0]  int_idx_d, fp_idx_d, int_idx_q, fp_idx_q;

  dpm_entry_store #(.N_ENTRIES(N_ENTRIES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_addr  (cfg_wr_addr),
    .wr_data  (map_entry_t'(cfg_wr_data)),
    .tbl_next (tbl_next)
  );

  dpm_reverse_builder #(.N_ENTRIES(N_ENTRIES)) u_build (
    .tbl     (tbl_next),
    .int_en  (int_en_d),
    .fp_en   (fp_en_d),
    .int_idx (int_idx_d),
    .fp_idx  (fp_idx_d)
  );

  dpm_reverse_regs u_rmap (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_en_d  (int_en_d),
    .fp_en_d   (fp_en_d),
    .int_idx_d (int_idx_d),
    .fp_idx_d  (fp_idx_d),
    .int_en_q  (int_en_q),
    .fp_en_q   (fp_en_q),
    .int_idx_q (int_idx_q),
    .fp_idx_q  (fp_idx_q)
  );

  dpm_lookup_port u_lookup (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_en      (int_en_q),
    .fp_en       (fp_en_q),
    .int_idx     (int_idx_q),
    .fp_idx      (fp_idx_q),
    .lk_valid    (lk_valid),
    .lk_ready    (lk_ready),
    .lk_is_fp    (lk_is_fp),
    .lk_dest     (lk_dest),
    .rs_valid    (rs_valid),
    .rs_ready    (rs_ready),
    .rs_pred_en  (rs_pred_en),
    .rs_pred_reg (rs_pred_reg)
  );
endmodule

// File: rtl/dpm_checker.sv
module dpm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       lk_valid,
  input logic       lk_ready,
  input logic       rs_valid,
  input logic       rs_ready,
  input logic       rs_pred_en,
  input logic [4:0] rs_pred_reg
);
  p_accept_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rs_valid);

  p_ready_rule_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |-> !lk_ready);

  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_ready && !lk_valid) |=> !rs_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=>
      (rs_valid && $stable(rs_pred_en) && $stable(rs_pred_reg)));

  p_zero_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_pred_en) |-> (rs_pred_reg == 5'd0));

  p_reset_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rs_valid);
endmodule

bind dest_pred_map dpm_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .lk_ready    (lk_ready),
  .rs_valid    (rs_valid),
  .rs_ready    (rs_ready),
  .rs_pred_en  (rs_pred_en),
  .rs_pred_reg (rs_pred_reg)
);

// File: tb/dest_pred_map_tb.sv
module dest_pred_map_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_wr_addr = '0;
  logic [11:0] cfg_wr_data = '0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic        lk_is_fp = 1'b0;
  logic [4:0]  lk_dest = '0;
  logic        rs_valid;
  logic        rs_ready = 1'b1;
  logic        rs_pred_en;
  logic [4:0]  rs_pred_reg;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [11:0] mdl [16];

  always #4 clk = ~clk;

  dest_pred_map u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_is_fp(lk_is_fp), .lk_dest(lk_dest), .rs_valid(rs_valid),
    .rs_ready(rs_ready), .rs_pred_en(rs_pred_en), .rs_pred_reg(rs_pred_reg)
  );

  function automatic logic [11:0] mk(input logic [4:0] pred, input logic en,
                                     input logic fp, input logic [4:0] tgt);
    return {pred, en, fp, tgt};
  endfunction

  // Table model: field layout per R1, highest slot wins per R5.
  function automatic logic [5:0] expect_of(input logic fp, input logic [4:0] d);
    logic [5:0] r = 6'd0;
    for (int e = 0; e < 16; e++)
      if (mdl[e][6] && (mdl[e][5] == fp) && (mdl[e][4:0] == d))
        r = {1'b1, mdl[e][11:7]};
    return r;
  endfunction

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    mdl[a] = d;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic query(input string tag, input logic fp, input logic [4:0] d);
    @(negedge clk);
    lk_valid = 1'b1; lk_is_fp = fp; lk_dest = d;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    chk({tag, " R8 valid"}, {5'd0, rs_valid}, 6'd1);
    chk(tag, {rs_pred_en, rs_pred_reg}, expect_of(fp, d));
  endtask

  task automatic sweep(input string tag);
    for (int f = 0; f < 2; f++)
      for (int d = 0; d < 32; d++)
        query(tag, f[0], d[4:0]);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    summary();
  end

  initial begin
    for (int e = 0; e < 16; e++) mdl[e] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset rs_valid", {5'd0, rs_valid}, 6'd0);
    rst_n = 1'b1;
    sweep("R7 after reset");

    // R1/R2/R4: distinct targets, alternating file type.
    for (int e = 0; e < 16; e++)
      wr(e[3:0], mk(5'((e * 5 + 3) % 32), 1'b1, e[0], 5'(e * 2 + 1)));
    sweep("R2 R4 distinct");

    // R3: disable half the slots, pred fields kept nonzero.
    for (int e = 0; e < 16; e += 2)
      wr(e[3:0], mk(5'(e + 9), 1'b0, e[0], 5'(e * 2 + 1)));
    sweep("R3 disabled");

    // R5: many slots on one target; highest enabled wins.
    for (int e = 0; e < 16; e++)
      wr(e[3:0], mk(5'(31 - e), (e % 3) != 2, 1'b0, 5'd7));
    query("R5 dup int", 1'b0, 5'd7);
    query("R4 other file", 1'b1, 5'd7);
    wr(4'd15, mk(5'd21, 1'b0, 1'b0, 5'd7));
    query("R5 top disabled", 1'b0, 5'd7);
    wr(4'd15, mk(5'd22, 1'b1, 1'b1, 5'd7));
    query("R5 top fp", 1'b1, 5'd7);
    query("R5 int fallback", 1'b0, 5'd7);
    sweep("R5 sweep");

    // R6: write and query in the same cycle sees the old table.
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = 4'd3; cfg_wr_data = mk(5'd30, 1'b1, 1'b1, 5'd30);
    lk_valid = 1'b1; lk_is_fp = 1'b1; lk_dest = 5'd30;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0; lk_valid = 1'b0;
    chk("R6 same cycle old", {rs_pred_en, rs_pred_reg}, expect_of(1'b1, 5'd30));
    mdl[3] = mk(5'd30, 1'b1, 1'b1, 5'd30);
    query("R6 next cycle new", 1'b1, 5'd30);
    wr(4'd3, mk(5'd1, 1'b1, 1'b0, 5'd2));
    query("R6 overwrite old gone", 1'b1, 5'd30);
    query("R6 overwrite new", 1'b0, 5'd2);

    // R9/R8: back-pressure.
    @(negedge clk);
    rs_ready = 1'b0; lk_valid = 1'b1; lk_is_fp = 1'b0; lk_dest = 5'd2;
    @(posedge clk);
    @(negedge clk);
    chk("R9 first", {rs_pred_en, rs_pred_reg}, expect_of(1'b0, 5'd2));
    chk("R8 ready low", {5'd0, lk_ready}, 6'd0);
    lk_is_fp = 1'b1; lk_dest = 5'd7;
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
      chk("R9 held valid", {5'd0, rs_valid}, 6'd1);
      chk("R9 held data", {rs_pred_en, rs_pred_reg}, expect_of(1'b0, 5'd2));
    end
    rs_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R8 drain accepts", {rs_pred_en, rs_pred_reg}, expect_of(1'b1, 5'd7));
    @(posedge clk);
    @(negedge clk);
    chk("R8 empty", {5'd0, rs_valid}, 6'd0);

    // R10 / R7: reset clears everything.
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int e = 0; e < 16; e++) mdl[e] = '0;
    sweep("R7 R10 re-reset");
    summary();
  end
endmodule